// File: doc/BRIEF.md
# Byte-Addressed Flash Programming Controller

This block connects a byte-wide data bus to a flash array organised as 16-bit words. The array itself is modelled here as a small register array. The bus reads flash contents one byte at a time. To write, it fills a temporary buffer that holds two words, and the controller then programs that double word into the array. Programming cannot set a bit that is already cleared, because each new word is ANDed into the stored word. The code section and the lock bits can only be returned to all ones by a chip erase. A chip erase starts when the command register holds the erase code and a dummy byte is then written to a high byte in the code section.

The bus address is split into fields. From the least significant bit upward, they are:

| Bits | Field |
|---|---|
| 0 | Byte select |
| 1 | Word within the two-word page |
| PAGE_BITS+1 : 2 | Page number |
| top two bits | Region |

There are four regions:

| Region code | Contents |
|---|---|
| 0 | Code section |
| 1 | Lock bits |
| 2 | Configuration byte |
| 3 | Signature and calibration bytes |

Program and erase operations hold a busy flag for fixed cycle counts, which are set by parameters. While the flag is set, every bus access is refused and recorded in a sticky error flag.

The controller is built around a four-state machine:

| State | Meaning |
|---|---|
| `S_IDLE` | Idle; bus accesses are served |
| `S_PROG` | Programming a double word |
| `S_ERASE` | Erasing the code section |
| `S_LOCKCLR` | Releasing the lock bits after an erase |

The transitions are:

- `S_IDLE` to `S_PROG`: the fourth buffer byte arrives in order.
- `S_IDLE` to `S_ERASE`: the erase trigger arrives.
- `S_PROG` to `S_IDLE`: the program count expires.
- `S_ERASE` to `S_LOCKCLR`: the erase count expires.
- `S_LOCKCLR` to `S_IDLE`: always, after one cycle.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A read sets `bus_rdata` on the clock edge that samples `bus_rd`. For the code section, address bit 0 equal to 0 returns the low byte of the addressed word, and 1 returns the high byte.
- R2: Region 2 reads return `CFG_BYTE`. Region 3 reads return `SIG_BYTE` at an even address and `CAL_BYTE` at an odd address. Writes to regions 2 and 3 change nothing.
- R3: Code writes fill the buffer in this order: low byte of word 0, high byte of word 0, low byte of word 1, high byte of word 1 (address bits [1:0] = 0, 1, 2, 3), all within one page. The fourth byte programs the double word and holds `busy` for exactly `PROG_CYC` cycles.
- R4: Programming stores the bitwise AND of the new word and the stored word.
- R5: A code write whose position or page is out of order is dropped and returns the fill pointer to the first low byte. No programming follows from it.
- R6: An erase starts only when `cmd_q` equals 8'hE5 and a write hits an odd address in the code section. With that command loaded, low-byte code writes and writes to other regions are ignored.
- R7: A chip erase sets every code word to 16'hFFFF and holds `busy` for exactly `ERASE_CYC`+1 cycles. The configuration, signature and calibration bytes are left unchanged.
- R8: The lock bits stay unchanged for every cycle in which `busy` is set during an erase. They become all ones only as `busy` falls. An idle write to region 1 ANDs the low `LOCK_W` data bits into the lock bits.
- R9: While `busy` is set, a read returns 8'h00, a write is dropped without moving the fill pointer, and `err` is set. A `cmd_wr` clears `err`.
- R10: After reset, `busy` and `err` are 0, `cmd_q` is 0, the lock bits equal `LOCK_INIT`, and every code byte reads 8'hFF. A lock-region read returns the lock bits in its low bits, padded with ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | PAGE_BITS+4 | Byte address: region, page, word, byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| cmd_wr | input | 1 | Command register write strobe; also clears `err` |
| cmd_wdata | input | 8 | Command value |
| cmd_q | output | 8 | Current command register |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky flag for refused accesses |
| lock_state | output | LOCK_W | Current lock bits |

## Verification
Read data is due on the first falling edge after the rising edge that samples `bus_rd`. The driver pushes each expected byte into a queue, and a monitor pops the queue at that falling edge. `busy` rises at the falling edge right after the fourth buffer byte or the erase trigger. The bench counts falling edges while `busy` is high and compares the count with `PROG_CYC` or `ERASE_CYC`+1. During an erase, the lock bits are sampled at every one of those edges. `err` and the absence of effect after an ignored write are checked one falling edge after the write, and then through read-back.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {S_IDLE, S_PROG, S_ERASE, S_LOCKCLR} fpc_state_t;
    typedef enum logic [1:0] {RG_CODE, RG_LOCK, RG_CFG, RG_SIGCAL} fpc_region_t;
    localparam logic [7:0] CMD_ERASE = 8'hE5;
endpackage

// File: rtl/fpc_wbuf.sv
module fpc_wbuf #(
    parameter int PAGE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           pos,
    input  logic [PAGE_BITS-1:0] page,
    input  logic [7:0]           data,
    output logic                 done,
    output logic [PAGE_BITS-1:0] page_q,
    output logic [15:0]          word0,
    output logic [15:0]          word1
);
    logic [1:0] fill_q;
    logic [7:0] b0_q, b1_q, b2_q;
    logic       in_order;

    assign in_order = (pos == fill_q) && (fill_q == 2'd0 || page == page_q);
    assign done     = wr_en && in_order && (fill_q == 2'd3);
    assign word0    = {b1_q, b0_q};
    assign word1    = {data, b2_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= 2'd0;
            page_q <= '0;
            b0_q   <= 8'h00;
            b1_q   <= 8'h00;
            b2_q   <= 8'h00;
        end else if (wr_en) begin
            if (in_order) begin
                fill_q <= fill_q + 2'd1;
                unique case (fill_q)
                    2'd0: begin b0_q <= data; page_q <= page; end
                    2'd1: b1_q <= data;
                    2'd2: b2_q <= data;
                    2'd3: ;
                endcase
            end else begin
                fill_q <= 2'd0;
            end
        end
    end

    // R5
    reorder_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pos != fill_q) |=> (fill_q == 2'd0));

    // R3
    fill_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (fill_q == 2'd0));
endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
    parameter int          PAGE_BITS = 3,
    parameter int          LOCK_W    = 2,
    parameter logic [LOCK_W-1:0] LOCK_INIT = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_en,
    input  logic [PAGE_BITS-1:0] prog_page,
    input  logic [15:0]          prog_w0,
    input  logic [15:0]          prog_w1,
    input  logic                 erase_en,
    input  logic [PAGE_BITS:0]   erase_idx,
    input  logic                 lock_clr,
    input  logic                 lock_wr,
    input  logic [LOCK_W-1:0]    lock_wdata,
    input  logic [PAGE_BITS:0]   rd_idx,
    output logic [15:0]          rd_word,
    output logic [LOCK_W-1:0]    lock_q
);
    localparam int WORDS = 2 << PAGE_BITS;

    logic [15:0] mem_q [WORDS];

    assign rd_word = mem_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= 16'hFFFF;
        end else if (prog_en) begin
            mem_q[{prog_page, 1'b0}] <= mem_q[{prog_page, 1'b0}] & prog_w0;
            mem_q[{prog_page, 1'b1}] <= mem_q[{prog_page, 1'b1}] & prog_w1;
        end else if (erase_en) begin
            mem_q[erase_idx] <= 16'hFFFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lock_q <= LOCK_INIT;
        else if (lock_clr) lock_q <= '1;
        else if (lock_wr)  lock_q <= lock_q & lock_wdata;
    end

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> $stable(lock_q));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int          PAGE_BITS = 3,
    parameter int          PROG_CYC  = 4,
    parameter int          ERASE_CYC = 20,
    parameter int          LOCK_W    = 2,
    parameter logic [LOCK_W-1:0] LOCK_INIT = '1,
    parameter logic [7:0]  CFG_BYTE  = 8'hA5,
    parameter logic [7:0]  SIG_BYTE  = 8'h3C,
    parameter logic [7:0]  CAL_BYTE  = 8'hC3,
    localparam int         ADDR_W    = PAGE_BITS + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_wdata,
    output logic [7:0]        cmd_q,
    output logic              busy,
    output logic              err,
    output logic [LOCK_W-1:0] lock_state
);
    localparam int CODE_WORDS = 2 << PAGE_BITS;
    localparam int MAX_CYC    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    fpc_state_t             state_q;
    logic [CNT_W-1:0]       cnt_q;
    fpc_region_t            region;
    logic                   idle, is_code;
    logic                   erase_go, buf_wr, lock_wr, prog_go;
    logic                   erase_en, lock_clr;
    logic [PAGE_BITS-1:0]   prog_page;
    logic [15:0]            w0, w1, rd_word;

    assign region  = fpc_region_t'(bus_addr[ADDR_W-1 -: 2]);
    assign is_code = (region == RG_CODE);
    assign idle    = (state_q == S_IDLE);

    assign erase_go = idle && bus_wr && is_code && bus_addr[0] && (cmd_q == CMD_ERASE);
    assign buf_wr   = idle && bus_wr && is_code && (cmd_q != CMD_ERASE);
    assign lock_wr  = idle && bus_wr && (region == RG_LOCK);

    fpc_wbuf #(.PAGE_BITS(PAGE_BITS)) u_wbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_wr),
        .pos    (bus_addr[1:0]),
        .page   (bus_addr[PAGE_BITS+1:2]),
        .data   (bus_wdata),
        .done   (prog_go),
        .page_q (prog_page),
        .word0  (w0),
        .word1  (w1)
    );

    fpc_array #(.PAGE_BITS(PAGE_BITS), .LOCK_W(LOCK_W), .LOCK_INIT(LOCK_INIT)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_go),
        .prog_page  (prog_page),
        .prog_w0    (w0),
        .prog_w1    (w1),
        .erase_en   (erase_en),
        .erase_idx  (cnt_q[PAGE_BITS:0]),
        .lock_clr   (lock_clr),
        .lock_wr    (lock_wr),
        .lock_wdata (bus_wdata[LOCK_W-1:0]),
        .rd_idx     (bus_addr[PAGE_BITS+1:1]),
        .rd_word    (rd_word),
        .lock_q     (lock_state)
    );

    // State register and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (erase_go) begin
                        state_q <= S_ERASE;
                        cnt_q   <= CNT_W'(ERASE_CYC - 1);
                    end else if (prog_go) begin
                        state_q <= S_PROG;
                        cnt_q   <= CNT_W'(PROG_CYC - 1);
                    end
                end
                S_PROG: begin
                    if (cnt_q == '0) state_q <= S_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                S_ERASE: begin
                    if (cnt_q == '0) state_q <= S_LOCKCLR;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                S_LOCKCLR: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy     = 1'b0;
        erase_en = 1'b0;
        lock_clr = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_PROG:    busy = 1'b1;
            S_ERASE: begin
                busy     = 1'b1;
                erase_en = (cnt_q < CNT_W'(CODE_WORDS));
            end
            S_LOCKCLR: begin
                busy     = 1'b1;
                lock_clr = 1'b1;
            end
        endcase
    end

    // Read path, command register, sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
            cmd_q     <= 8'h00;
            err       <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= cmd_wdata;
                err   <= 1'b0;
            end
            if (busy && (bus_rd || bus_wr)) err <= 1'b1;
            if (bus_rd) begin
                if (busy) bus_rdata <= 8'h00;
                else begin
                    unique case (region)
                        RG_CODE:   bus_rdata <= bus_addr[0] ? rd_word[15:8] : rd_word[7:0];
                        RG_LOCK:   bus_rdata <= {{(8-LOCK_W){1'b1}}, lock_state};
                        RG_CFG:    bus_rdata <= CFG_BYTE;
                        RG_SIGCAL: bus_rdata <= bus_addr[0] ? CAL_BYTE : SIG_BYTE;
                    endcase
                end
            end
        end
    end

    // R9
    refuse_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_rd) |=> (bus_rdata == 8'h00 && err));

    // R3
    prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROG && $past(state_q) == S_IDLE) |-> $past(bus_addr[1:0]) == 2'd3);

    // R6
    erase_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ERASE && $past(state_q) == S_IDLE) |-> ($past(cmd_q) == CMD_ERASE && $past(bus_addr[0])));

    // R7
    erase_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ERASE && cnt_q == '0) |=> (state_q == S_LOCKCLR));
endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;
    localparam int PROG_CYC  = 4;
    localparam int ERASE_CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = '0, cmd_q;
    logic       busy, err;
    logic [1:0] lock_state;

    int tests = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    flash_prog_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_q(cmd_q), .busy(busy), .err(err), .lock_state(lock_state)
    );

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ca(int page, int w, int b);
        return 7'((page << 2) | (w << 1) | b);
    endfunction

    task automatic wr(logic [6:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cmd(logic [7:0] v);
        cmd_wdata = v; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic prog(int page, logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
        wr(ca(page, 0, 0), a);
        wr(ca(page, 0, 1), b);
        wr(ca(page, 1, 0), c);
        wr(ca(page, 1, 1), d);
    endtask

    task automatic busy_len(string tag, int exp, bit watch_lock);
        int n = 0;
        while (busy && n < 100) begin
            if (watch_lock) check("R8 lock held during erase", lock_state, 0);
            n++;
            @(negedge clk);
        end
        check(tag, n, exp);
    endtask

    // Scoreboard monitor: read data due at the falling edge after the sampling edge
    always @(posedge clk) begin
        if (bus_rd) begin
            @(negedge clk);
            if (exp_q.size() == 0) check("monitor queue empty", 1, 0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", busy, 0);
        check("R10 err", err, 0);
        check("R10 cmd", cmd_q, 0);
        check("R10 lock", lock_state, 2'b11);
        rd(7'h20, 8'hFF, "R10 lock read");
        rd(ca(5, 1, 1), 8'hFF, "R10 erased code");

        // R3 program page 2, busy length
        prog(2, 8'h34, 8'h12, 8'h78, 8'h56);
        busy_len("R3 program busy cycles", PROG_CYC, 1'b0);
        // R1 byte select
        rd(ca(2, 0, 0), 8'h34, "R1 w0 low");
        rd(ca(2, 0, 1), 8'h12, "R1 w0 high");
        rd(ca(2, 1, 0), 8'h78, "R1 w1 low");
        rd(ca(2, 1, 1), 8'h56, "R1 w1 high");

        // R4 AND into stored bits
        prog(2, 8'h0F, 8'hF0, 8'hFF, 8'h00);
        busy_len("R4 program busy cycles", PROG_CYC, 1'b0);
        rd(ca(2, 0, 0), 8'h04, "R4 w0 low");
        rd(ca(2, 0, 1), 8'h10, "R4 w0 high");
        rd(ca(2, 1, 0), 8'h78, "R4 w1 low");
        rd(ca(2, 1, 1), 8'h00, "R4 w1 high");

        // R5 out-of-order write drops and restarts
        wr(ca(3, 0, 0), 8'h01);
        wr(ca(3, 1, 1), 8'h02);
        check("R5 no program after reorder", busy, 0);
        wr(ca(3, 0, 1), 8'h03);
        wr(ca(3, 1, 0), 8'h04);
        wr(ca(3, 1, 1), 8'h05);
        check("R5 stray sequence ignored", busy, 0);
        rd(ca(3, 0, 0), 8'hFF, "R5 page untouched");
        prog(3, 8'hAA, 8'hBB, 8'hCC, 8'hDD);
        busy_len("R5 restart programs", PROG_CYC, 1'b0);
        rd(ca(3, 1, 1), 8'hDD, "R5 restarted data");
        rd(ca(3, 0, 0), 8'hAA, "R5 restarted low");

        // R9 refusal while busy
        prog(4, 8'h11, 8'h22, 8'h33, 8'h44);
        rd(ca(4, 0, 0), 8'h00, "R9 refused read");
        check("R9 err set", err, 1);
        wr(ca(0, 0, 0), 8'h00);
        while (busy) @(negedge clk);
        rd(ca(0, 0, 0), 8'hFF, "R9 dropped write");
        rd(ca(4, 0, 0), 8'h11, "R9 program completed");
        prog(1, 8'h5A, 8'hFF, 8'hFF, 8'hFF);
        while (busy) @(negedge clk);
        rd(ca(1, 0, 0), 8'h5A, "R9 pointer unmoved");
        cmd(8'h00);
        @(negedge clk);
        check("R9 err cleared", err, 0);

        // R2 fixed regions
        rd(7'h40, 8'hA5, "R2 config");
        rd(7'h60, 8'h3C, "R2 signature");
        rd(7'h61, 8'hC3, "R2 calibration");
        wr(7'h40, 8'h00);
        wr(7'h61, 8'h00);
        rd(7'h40, 8'hA5, "R2 config write ignored");
        rd(7'h61, 8'hC3, "R2 calibration write ignored");

        // R8 lock write ANDs
        wr(7'h20, 8'hFC);
        check("R8 lock write", lock_state, 0);
        rd(7'h20, 8'hFC, "R8 lock read");

        // R6 erase trigger rules
        cmd(8'hE5);
        check("R6 cmd loaded", cmd_q, 8'hE5);
        wr(ca(2, 0, 0), 8'h00);
        check("R6 low byte no erase", busy, 0);
        wr(7'h61, 8'h00);
        check("R6 other region no erase", busy, 0);
        rd(ca(2, 0, 0), 8'h04, "R6 data intact");

        // R7 / R8 erase
        wr(ca(6, 0, 1), 8'h99);
        busy_len("R7 erase busy cycles", ERASE_CYC + 1, 1'b1);
        check("R8 lock released after erase", lock_state, 2'b11);
        rd(ca(2, 0, 0), 8'hFF, "R7 erased p2");
        rd(ca(3, 1, 1), 8'hFF, "R7 erased p3");
        rd(ca(4, 0, 0), 8'hFF, "R7 erased p4");
        rd(ca(1, 0, 0), 8'hFF, "R7 erased p1");
        rd(7'h40, 8'hA5, "R7 config kept");
        rd(7'h60, 8'h3C, "R7 signature kept");
        rd(7'h20, 8'hFF, "R8 lock read after erase");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule